// File: doc/BRIEF.md
# FIFO Flag Threshold Offset Programmer

This block stores the two distance values that a FIFO's almost-empty and almost-full comparators measure against. Each value says how many words away from the empty or the full boundary the matching flag switches. The values come in on one of two paths. The parallel path takes them from the FIFO's data input bus. The serial path shifts them in one bit per write-clock edge. Both values can be read back over a parallel data bus.

A master reset selects the loading path and loads a pair of default thresholds. The load control input sets both choices during that reset. The chosen path stays in force until the next master reset. Programming can be split into pieces and mixed with ordinary FIFO writes. While the load control is high, a write strobe goes to the FIFO memory through the memory-write output. When the load control falls again, programming resumes at the next register part or bit. The write sequence and the readback sequence each have their own pointer, and the two pointers move independently.

The width-mode input changes how a value is split. In wide mode each offset is one bus-wide register. In narrow mode each offset is split into a low byte and a high part. A partial reset leaves all of this state untouched.

Top module: `fifo_ofs_prog`

## Requirements
- R1: Master reset is `mrst_n` low, sampled on a rising `clk` edge. If `ld_n` is low at that edge, the parallel path is selected, both offsets become 127 (0x07F) and `flags_valid` is 1. If `ld_n` is high, the serial path is selected, both offsets become 1023 (0x3FF) and `flags_valid` is 0. Both pointers return to part 0, the empty-offset low part.
- R2: The path selected at master reset cannot change before the next master reset. On the parallel path, serial strobes (`sen_n` low) change nothing. On the serial path, parallel strobes (`wen_n` low with `ld_n` low) change nothing.
- R3: Wide mode (`narrow`=0) on the parallel path: each edge with `ld_n` and `wen_n` both low writes `din[OFS_W-1:0]` into the register at the write pointer. The order is empty offset (part 0), then full offset (part 2), then back to the empty offset.
- R4: Narrow mode (`narrow`=1) on the parallel path: writes go to empty bits [7:0] from `din[7:0]` (part 0), then empty bits [OFS_W-1:8] from `din[OFS_W-9:0]` (part 1), then full bits [7:0] (part 2), then full bits [OFS_W-1:8] (part 3). After part 3 the pointer wraps to part 0.
- R5: Serial path: each edge with `ld_n` and `sen_n` both low takes `sdi` as the next bit. Bits arrive least-significant first, the empty offset before the full offset. A full pass is 2*OFS_W bits, after which the next bit goes to empty bit 0. Because the low part comes before the high part of each offset, the bit order is the same in both width modes.
- R6: On the serial path, an edge with `ld_n` low and `sen_n` high writes nothing.
- R7: An edge with `prst_n` low (and `mrst_n` high) leaves both offsets, both pointers and `flags_valid` unchanged. Any load or read requested on that edge is ignored.
- R8: `mem_wr` is high exactly when `ld_n` is high and `wen_n` is low, and such an edge leaves the offsets unchanged. When `ld_n` goes low again, programming continues where it stopped.
- R9: On the serial path, `flags_valid` rises on the edge that takes the last bit of a full pass. It then stays high until the next master reset.
- R10: `rdata` shows the part at the read pointer, zero-extended. In wide mode that is a whole offset. In narrow mode it is the byte or high part. An edge with `ld_n` low and `rd_req` high moves the read pointer one step, in the same order as R3 or R4, on either path.
- R11: If an offset write (R3, R4 or R5) and a read request fall on the same edge, the write takes effect and the read pointer stays where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge active |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| ld_n | input | 1 | Load control; path select during master reset, offset access enable afterwards |
| wen_n | input | 1 | Write enable, active low |
| sen_n | input | 1 | Serial enable, active low |
| sdi | input | 1 | Serial offset data |
| narrow | input | 1 | Width mode: 1 splits each offset into byte and high part |
| din | input | DATA_W | Data input bus |
| rd_req | input | 1 | Offset readback advance request |
| empty_ofs | output | OFS_W | Almost-empty threshold offset |
| full_ofs | output | OFS_W | Almost-full threshold offset |
| rdata | output | DATA_W | Readback of the part at the read pointer |
| flags_valid | output | 1 | Thresholds are complete and usable |
| mem_wr | output | 1 | Ordinary write routed to the FIFO memory |

## Verification
The hardest situation to reach is a serial pass that is broken by memory writes, ignored serial-enable-high edges and partial resets, and then resumed to completion. Only in that case does a wrong bit counter or an early `flags_valid` show up. The random phases hold `ld_n` low most of the time and toggle `sen_n`, `wen_n`, `rd_req` and the rare `prst_n` from a fixed seed, so many passes wrap past 2*OFS_W bits with such gaps inside them. Directed cases cover a read request on the same edge as a write, and the part-3 wrap in narrow mode.

// File: rtl/fop_pkg.sv
package fop_pkg;

   typedef enum logic {
      LOAD_PAR = 1'b0,
      LOAD_SER = 1'b1
   } load_mode_e;

   typedef logic [1:0] part_idx_t;

   localparam int LO_W      = 8;
   localparam int DFLT_PAR  = 127;
   localparam int DFLT_SER  = 1023;

   // step order of a register-part pointer: 0,1,2,3 when split, 0,2 when whole
   function automatic part_idx_t part_next(input part_idx_t p, input logic split);
      part_idx_t n;
      if (split) n = p + 2'd1;
      else       n = {~p[1], 1'b0};
      return n;
   endfunction

endpackage

// File: rtl/fop_part_ptr.sv
module fop_part_ptr
   import fop_pkg::*;
(
   input  logic      clk,
   input  logic      mrst_n,
   input  logic      step,
   input  logic      split,
   output part_idx_t part
);

   part_idx_t part_q;

   always_ff @(posedge clk) begin
      if (!mrst_n)   part_q <= '0;
      else if (step) part_q <= part_next(part_q, split);
   end

   assign part = part_q;

endmodule

// File: rtl/fop_ser_cnt.sv
module fop_ser_cnt #(
   parameter int OFS_W = 13,
   localparam int NBITS = 2 * OFS_W,
   localparam int IDX_W = $clog2(NBITS)
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic             preset_valid,
   input  logic             shift,
   output logic [IDX_W-1:0] bit_idx,
   output logic             valid
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NBITS - 1);

   logic [IDX_W-1:0] idx_q;
   logic             valid_q;

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         idx_q   <= '0;
         valid_q <= preset_valid;
      end else if (shift) begin
         if (idx_q == LAST) begin
            idx_q   <= '0;
            valid_q <= 1'b1;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign bit_idx = idx_q;
   assign valid   = valid_q;

endmodule

// File: rtl/fop_ofs_bank.sv
module fop_ofs_bank
   import fop_pkg::*;
#(
   parameter int OFS_W  = 13,
   parameter int DATA_W = 18,
   localparam int IDX_W = $clog2(2 * OFS_W),
   localparam int HI_W  = OFS_W - LO_W
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              big_dflt,
   input  logic              split,
   input  logic              par_we,
   input  part_idx_t         par_part,
   input  logic [DATA_W-1:0] din,
   input  logic              ser_we,
   input  logic [IDX_W-1:0]  ser_idx,
   input  logic              sdi,
   output logic [OFS_W-1:0]  empty_ofs,
   output logic [OFS_W-1:0]  full_ofs
);

   logic [OFS_W-1:0] ofs_q [2];

   // entry 0 is the empty-side offset, entry 1 the full-side offset
   for (genvar g = 0; g < 2; g++) begin : g_ofs
      localparam int        BASE   = g * OFS_W;
      localparam part_idx_t LO_SEL = 2'(2 * g);
      localparam part_idx_t HI_SEL = 2'(2 * g + 1);

      always_ff @(posedge clk) begin
         if (!mrst_n) begin
            ofs_q[g] <= big_dflt ? OFS_W'(DFLT_SER) : OFS_W'(DFLT_PAR);
         end else if (par_we && par_part == LO_SEL) begin
            if (split) ofs_q[g][LO_W-1:0] <= din[LO_W-1:0];
            else       ofs_q[g]           <= din[OFS_W-1:0];
         end else if (par_we && split && par_part == HI_SEL) begin
            ofs_q[g][OFS_W-1:LO_W] <= din[HI_W-1:0];
         end else if (ser_we) begin
            for (int b = 0; b < OFS_W; b++) begin
               if (ser_idx == IDX_W'(BASE + b)) ofs_q[g][b] <= sdi;
            end
         end
      end
   end

   assign empty_ofs = ofs_q[0];
   assign full_ofs  = ofs_q[1];

endmodule

// File: rtl/fop_rd_mux.sv
module fop_rd_mux
   import fop_pkg::*;
#(
   parameter int OFS_W  = 13,
   parameter int DATA_W = 18
) (
   input  part_idx_t         part,
   input  logic              split,
   input  logic [OFS_W-1:0]  empty_ofs,
   input  logic [OFS_W-1:0]  full_ofs,
   output logic [DATA_W-1:0] rdata
);

   logic [OFS_W-1:0] sel;

   always_comb begin
      sel = part[1] ? full_ofs : empty_ofs;
      if (!split)       rdata = DATA_W'(sel);
      else if (part[0]) rdata = DATA_W'(sel[OFS_W-1:LO_W]);
      else              rdata = DATA_W'(sel[LO_W-1:0]);
   end

endmodule

// File: rtl/fifo_ofs_prog.sv
module fifo_ofs_prog
   import fop_pkg::*;
#(
   parameter int OFS_W  = 13,
   parameter int DATA_W = 18,
   localparam int IDX_W = $clog2(2 * OFS_W)
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              ld_n,
   input  logic              wen_n,
   input  logic              sen_n,
   input  logic              sdi,
   input  logic              narrow,
   input  logic [DATA_W-1:0] din,
   input  logic              rd_req,
   output logic [OFS_W-1:0]  empty_ofs,
   output logic [OFS_W-1:0]  full_ofs,
   output logic [DATA_W-1:0] rdata,
   output logic              flags_valid,
   output logic              mem_wr
);

   if (OFS_W < 10 || OFS_W > 2 * LO_W) begin : g_bad_ofs_w
      initial $fatal(1, "OFS_W must lie in 10..16");
   end
   if (DATA_W < OFS_W) begin : g_bad_data_w
      initial $fatal(1, "DATA_W must be at least OFS_W");
   end

   load_mode_e       mode_q;
   logic             live;
   logic             par_we;
   logic             ser_we;
   logic             rd_step;
   part_idx_t        wr_part;
   part_idx_t        rd_part;
   logic [IDX_W-1:0] ser_idx;

   always_ff @(posedge clk) begin
      if (!mrst_n) mode_q <= ld_n ? LOAD_SER : LOAD_PAR;
   end

   assign live    = mrst_n && prst_n;
   assign par_we  = live && !ld_n && !wen_n && (mode_q == LOAD_PAR);
   assign ser_we  = live && !ld_n && !sen_n && (mode_q == LOAD_SER);
   assign rd_step = live && !ld_n && rd_req && !(par_we || ser_we);
   assign mem_wr  = ld_n && !wen_n;

   fop_part_ptr u_wr_ptr (
      .clk    (clk),
      .mrst_n (mrst_n),
      .step   (par_we),
      .split  (narrow),
      .part   (wr_part)
   );

   fop_part_ptr u_rd_ptr (
      .clk    (clk),
      .mrst_n (mrst_n),
      .step   (rd_step),
      .split  (narrow),
      .part   (rd_part)
   );

   fop_ser_cnt #(.OFS_W(OFS_W)) u_ser (
      .clk          (clk),
      .mrst_n       (mrst_n),
      .preset_valid (!ld_n),
      .shift        (ser_we),
      .bit_idx      (ser_idx),
      .valid        (flags_valid)
   );

   fop_ofs_bank #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_bank (
      .clk       (clk),
      .mrst_n    (mrst_n),
      .big_dflt  (ld_n),
      .split     (narrow),
      .par_we    (par_we),
      .par_part  (wr_part),
      .din       (din),
      .ser_we    (ser_we),
      .ser_idx   (ser_idx),
      .sdi       (sdi),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs)
   );

   fop_rd_mux #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rd_mux (
      .part      (rd_part),
      .split     (narrow),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs),
      .rdata     (rdata)
   );

endmodule

// File: rtl/fop_chk.sv
module fop_chk #(
   parameter int OFS_W  = 13,
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              mrst_n,
   input logic              prst_n,
   input logic              ld_n,
   input logic              wen_n,
   input logic              sen_n,
   input logic [OFS_W-1:0]  empty_ofs,
   input logic [OFS_W-1:0]  full_ofs,
   input logic [DATA_W-1:0] rdata,
   input logic              flags_valid,
   input logic              mem_wr,
   input logic              mode_q
);

   logic seen_rst = 1'b0;

   always_ff @(posedge clk) begin
      if (!mrst_n) seen_rst <= 1'b1;
   end

   assert_par_dflt_R1: assert property (@(posedge clk) disable iff (!seen_rst)
      (!mrst_n && !ld_n) |=> (empty_ofs == OFS_W'(127) && full_ofs == OFS_W'(127) && flags_valid));

   assert_ser_dflt_R1: assert property (@(posedge clk) disable iff (!seen_rst)
      (!mrst_n && ld_n) |=> (empty_ofs == OFS_W'(1023) && full_ofs == OFS_W'(1023) && !flags_valid));

   assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!mrst_n || !seen_rst)
      $past(mrst_n) |-> $stable(mode_q));

   assert_par_ignores_ser_R2: assert property (@(posedge clk) disable iff (!mrst_n)
      (!mode_q && wen_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

   assert_ser_idle_R6: assert property (@(posedge clk) disable iff (!mrst_n)
      (mode_q && !ld_n && sen_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

   assert_prst_hold_R7: assert property (@(posedge clk) disable iff (!mrst_n)
      !prst_n |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(flags_valid)));

   assert_memwr_no_ofs_R8: assert property (@(posedge clk) disable iff (!mrst_n)
      mem_wr |=> ($stable(empty_ofs) && $stable(full_ofs)));

   assert_valid_sticky_R9: assert property (@(posedge clk) disable iff (!mrst_n)
      flags_valid |=> flags_valid);

endmodule

bind fifo_ofs_prog fop_chk #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .mrst_n      (mrst_n),
   .prst_n      (prst_n),
   .ld_n        (ld_n),
   .wen_n       (wen_n),
   .sen_n       (sen_n),
   .empty_ofs   (empty_ofs),
   .full_ofs    (full_ofs),
   .rdata       (rdata),
   .flags_valid (flags_valid),
   .mem_wr      (mem_wr),
   .mode_q      (mode_q)
);

// File: tb/sim_fifo_ofs_prog.sv
`timescale 1ns/1ps
module sim_fifo_ofs_prog;

   localparam int W  = 13;
   localparam int DW = 18;
   localparam int NB = 2 * W;

   logic          clk = 1'b0;
   logic          mrst_n = 1'b1, prst_n = 1'b1, ld_n = 1'b1, wen_n = 1'b1, sen_n = 1'b1;
   logic          sdi = 1'b0, narrow = 1'b0, rd_req = 1'b0;
   logic [DW-1:0] din = '0;
   logic [W-1:0]  empty_ofs, full_ofs;
   logic [DW-1:0] rdata;
   logic          flags_valid, mem_wr;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // bench-side expected state
   bit         m_ser;
   logic [W-1:0] m_e, m_f;
   int         m_wp, m_rp, m_bi;
   bit         m_valid;

   always #4 clk = ~clk;

   fifo_ofs_prog #(.OFS_W(W), .DATA_W(DW)) u0 (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_n(ld_n), .wen_n(wen_n),
      .sen_n(sen_n), .sdi(sdi), .narrow(narrow), .din(din), .rd_req(rd_req),
      .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rdata(rdata),
      .flags_valid(flags_valid), .mem_wr(mem_wr)
   );

   function automatic int nxt(input int p);
      if (narrow) return (p + 1) % 4;
      return (p == 0) ? 2 : 0;
   endfunction

   function automatic logic [DW-1:0] exp_rd();
      logic [W-1:0] s;
      s = (m_rp >= 2) ? m_f : m_e;
      if (!narrow)          return DW'(s);
      if (m_rp % 2 == 1)    return DW'(s[W-1:8]);
      return DW'(s[7:0]);
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at the falling edge, update the model, compare at the next falling edge
   task automatic step(input logic m, input logic p, input logic l, input logic w,
                       input logic s, input logic sd, input logic [DW-1:0] d,
                       input logic r, input string tag);
      bit pw, sw;
      mrst_n = m; prst_n = p; ld_n = l; wen_n = w; sen_n = s; sdi = sd; din = d; rd_req = r;
      #1;
      chk("R8", "mem_wr", 32'(mem_wr), 32'(l && !w));
      if (!m) begin
         m_ser = l; m_e = l ? W'(1023) : W'(127); m_f = m_e;
         m_wp = 0; m_rp = 0; m_bi = 0; m_valid = !l;
      end else if (p) begin
         pw = !l && !w && !m_ser;
         sw = !l && !s && m_ser;
         if (pw) begin
            case (m_wp)
               0: if (narrow) m_e[7:0] = d[7:0]; else m_e = d[W-1:0];
               1: m_e[W-1:8] = d[W-9:0];
               2: if (narrow) m_f[7:0] = d[7:0]; else m_f = d[W-1:0];
               default: m_f[W-1:8] = d[W-9:0];
            endcase
            m_wp = nxt(m_wp);
         end
         if (sw) begin
            if (m_bi < W) m_e[m_bi] = sd; else m_f[m_bi - W] = sd;
            if (m_bi == NB - 1) begin m_bi = 0; m_valid = 1; end
            else m_bi++;
         end
         if (!l && r && !(pw || sw)) m_rp = nxt(m_rp);
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag, "empty_ofs", 32'(empty_ofs), 32'(m_e));
      chk(tag, "full_ofs", 32'(full_ofs), 32'(m_f));
      chk(tag, "flags_valid", 32'(flags_valid), 32'(m_valid));
      chk(tag, "rdata", 32'(rdata), 32'(exp_rd()));
   endtask

   task automatic mreset(input logic l, input string tag);
      step(0, 1, l, 1, 1, 0, '0, 0, tag);
   endtask

   task automatic pwr(input logic [DW-1:0] d, input string tag);
      step(1, 1, 0, 0, 1, 0, d, 0, tag);
   endtask

   task automatic rd(input string tag);
      step(1, 1, 0, 1, 1, 0, '0, 1, tag);
   endtask

   task automatic sbit(input logic b, input string tag);
      step(1, 1, 0, 1, 0, b, '0, 0, tag);
   endtask

   task automatic rand_phase(input int n);
      for (int i = 0; i < n; i++) begin
         logic l, w, s, r, p;
         l = ($urandom % 10) < 2;
         w = ($urandom % 3) == 0;
         s = ($urandom % 3) == 0;
         r = ($urandom % 4) == 0;
         p = ($urandom % 25) != 0;
         step(1, p, l, w, s, 1'($urandom), DW'($urandom), r, "R5_R10_R11_rand");
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0f0f));
      @(negedge clk);

      // wide, parallel path
      narrow = 0;
      mreset(0, "R1_par");
      pwr(18'h01234, "R3");
      pwr(18'h00abc, "R3");
      pwr(18'h01555, "R3_wrap");
      rd("R10");
      rd("R10_wrap");
      step(1, 1, 0, 0, 1, 0, 18'h00777, 1, "R11_par");   // full offset written, read pointer stays
      step(1, 1, 1, 0, 1, 0, 18'h01fff, 0, "R8_memwr");  // ordinary write, offsets untouched
      pwr(18'h00321, "R8_resume");                        // resumes at the empty offset
      step(1, 1, 0, 1, 0, 1, '0, 0, "R2_par_no_ser");
      step(1, 0, 0, 0, 1, 0, 18'h00fff, 1, "R7_prst");

      // narrow, parallel path
      narrow = 1;
      mreset(0, "R1_par_narrow");
      pwr(18'h000a5, "R4");
      pwr(18'h0001b, "R4");
      pwr(18'h0003c, "R4");
      pwr(18'h00007, "R4");
      pwr(18'h000ff, "R4_wrap");
      for (int k = 0; k < 5; k++) rd("R10_narrow");

      // wide, serial path
      narrow = 0;
      mreset(1, "R1_ser");
      pwr(18'h00111, "R2_ser_no_par");
      step(1, 1, 0, 1, 1, 1, '0, 0, "R6");
      for (int k = 0; k < NB; k++) begin
         if (k == 9)  step(1, 1, 1, 0, 1, 1, 18'h00aaa, 0, "R8_ser_interrupt");
         if (k == 15) step(1, 0, 0, 1, 0, 1, '0, 1, "R7_ser");
         if (k == 20) step(1, 1, 0, 1, 0, 1'(k), '0, 1, "R11_ser");
         else         sbit(1'((k * 7 + 3) % 5 == 0), "R5_R9");
      end
      rd("R10_ser");
      sbit(1'b0, "R5_wrap");

      // narrow, serial path
      narrow = 1;
      mreset(1, "R1_ser_narrow");
      for (int k = 0; k < NB; k++) sbit(1'(k % 3 == 1), "R5_narrow_R9");
      for (int k = 0; k < 4; k++) rd("R10_ser_narrow");

      // random phases for each configuration
      for (int c = 0; c < 4; c++) begin
         narrow = 1'(c % 2);
         mreset(1'(c / 2), "R1_rand");
         rand_phase(3000);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule